// File: doc/BRIEF.md
# Branch Target and Call Unit

This block works out the next program-counter value for the control-transfer instructions of an 8-bit microcontroller. On a one-cycle `start` strobe it takes the current PC, an instruction class chosen by the decoder, the immediate operand, the accumulator, the data pointer, the stack pointer and a branch-condition bit. It then produces the new PC and the new stack pointer. Relative branches, jumps within a page, long jumps and the jump through accumulator plus data pointer finish on the next cycle. Calls and returns move the 16-bit return address through a byte-wide stack port, one byte per cycle.

The decoder evaluates branch conditions and classifies opcodes before this block sees them. The block owns only target formation and the return-address traffic. The stack memory sits outside the block. It has a synchronous read: data requested in one cycle is presented on `stk_rdata` in the next cycle.

Top module: `pc_redirect_unit`

## Requirements
- R1: With `op_kind`=0 (relative) and `take`=1, `pc_new` is `pc_cur`+2 plus `imm[7:0]` read as a two's-complement offset, taken modulo 2^16.
- R2: With `op_kind`=0 and `take`=0, `pc_new` is `pc_cur`+2, `sp_new` equals `sp_cur`, and no stack read or write occurs.
- R3: With `op_kind`=1 (page jump) or 4 (page call), the low PAGE_W bits of `pc_new` come from `imm` and the upper bits come from `pc_cur`+2, so the page is taken after the PC has stepped past the instruction.
- R4: With `op_kind`=2 (long jump) or 5 (long call), `pc_new` equals `imm`.
- R5: With `op_kind`=3 (indexed jump), `pc_new` is `dptr` plus zero-extended `acc`, modulo 2^16.
- R6: A call stores the return address, which is `pc_cur`+2 for a page call and `pc_cur`+3 for a long call. It writes the low byte at `sp_cur`+1 and, on the next cycle, the high byte at `sp_cur`+2. `sp_new` is then `sp_cur`+2, modulo 2^SPW.
- R7: With `op_kind`=6 or 7 (return), the block reads address `sp_cur` and then `sp_cur`-1 on consecutive cycles. `pc_new` is {byte at `sp_cur`, byte at `sp_cur`-1}, and `sp_new` is `sp_cur`-2, modulo 2^SPW.
- R8: `done` is a one-cycle pulse that carries the result. It comes 1 cycle after `start` for jumps, 3 cycles after for calls and 4 cycles after for returns. `busy` is high from the cycle after `start` through the `done` cycle.
- R9: `start` is ignored while `busy` is high. The operation in progress completes with its own result and no further `done` follows.
- R10: Stack read and write strobes are never active together, and neither is active outside calls and returns.
- R11: During reset, `busy`, `done`, `stk_we` and `stk_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation |
| op_kind | input | 3 | Instruction class (encoding in R1-R7 text) |
| pc_cur | input | 16 | Address of the current instruction |
| imm | input | 16 | Operand: offset, page address or long address |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| sp_cur | input | SPW | Stack pointer |
| take | input | 1 | Branch condition for relative branches |
| stk_rdata | input | 8 | Stack read data, one cycle after the read strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| pc_new | output | 16 | Next PC |
| sp_new | output | SPW | Next stack pointer |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | SPW | Stack address |
| stk_wdata | output | 8 | Stack write data |

## Verification
The bench builds the block with its default values, PAGE_W=11 and SPW=8. With these values a 256-byte stack model covers the whole stack space, so a push from SP=FFh and a pop from SP=00h exercise wrap of the stack pointer. A page jump placed at the last two bytes of a 2 KB page shows which page the upper PC bits are taken from. Negative offsets and data-pointer sums near FFFFh exercise the 16-bit wrap of the PC.

// File: rtl/pc_redirect_unit.sv
module pc_redirect_unit #(
  parameter int PAGE_W = 11,
  parameter int SPW    = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op_kind,
  input  logic [15:0]    pc_cur,
  input  logic [15:0]    imm,
  input  logic [7:0]     acc,
  input  logic [15:0]    dptr,
  input  logic [SPW-1:0] sp_cur,
  input  logic           take,
  input  logic [7:0]     stk_rdata,
  output logic           busy,
  output logic           done,
  output logic [15:0]    pc_new,
  output logic [SPW-1:0] sp_new,
  output logic           stk_we,
  output logic           stk_re,
  output logic [SPW-1:0] stk_addr,
  output logic [7:0]     stk_wdata
);
  localparam logic [SPW-1:0] ONE = SPW'(1);
  localparam logic [SPW-1:0] TWO = SPW'(2);

  typedef enum logic [2:0] {S_IDLE, S_PUSH_LO, S_PUSH_HI, S_POP_HI, S_POP_LO, S_POP_END, S_FIN} st_t;

  st_t            st;
  logic [15:0]    ret_q, tgt_q, seq, tgt;
  logic [SPW-1:0] sp_q;
  logic [1:0]     len;

  always_comb begin
    case (op_kind)
      3'd0, 3'd1, 3'd4: len = 2'd2;
      3'd2, 3'd5:       len = 2'd3;
      default:          len = 2'd1;
    endcase
  end

  assign seq = pc_cur + {14'd0, len};

  always_comb begin
    case (op_kind)
      3'd0:       tgt = take ? seq + {{8{imm[7]}}, imm[7:0]} : seq;
      3'd1, 3'd4: tgt = {seq[15:PAGE_W], imm[PAGE_W-1:0]};
      3'd2, 3'd5: tgt = imm;
      3'd3:       tgt = dptr + {8'd0, acc};
      default:    tgt = seq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ret_q <= '0;
      tgt_q <= '0;
      sp_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ret_q <= seq;
          tgt_q <= tgt;
          sp_q  <= sp_cur;
          case (op_kind)
            3'd4, 3'd5: st <= S_PUSH_LO;
            3'd6, 3'd7: st <= S_POP_HI;
            default:    st <= S_FIN;
          endcase
        end
        S_PUSH_LO: st <= S_PUSH_HI;
        S_PUSH_HI: begin
          sp_q <= sp_q + TWO;
          st   <= S_FIN;
        end
        S_POP_HI: st <= S_POP_LO;
        S_POP_LO: begin
          tgt_q[15:8] <= stk_rdata;
          st          <= S_POP_END;
        end
        S_POP_END: begin
          tgt_q[7:0] <= stk_rdata;
          sp_q       <= sp_q - TWO;
          st         <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign pc_new    = tgt_q;
  assign sp_new    = sp_q;
  assign stk_we    = (st == S_PUSH_LO) || (st == S_PUSH_HI);
  assign stk_re    = (st == S_POP_HI) || (st == S_POP_LO);
  assign stk_wdata = (st == S_PUSH_HI) ? ret_q[15:8] : ret_q[7:0];

  always_comb begin
    case (st)
      S_PUSH_LO: stk_addr = sp_q + ONE;
      S_PUSH_HI: stk_addr = sp_q + TWO;
      S_POP_HI:  stk_addr = sp_q;
      S_POP_LO:  stk_addr = sp_q - ONE;
      default:   stk_addr = '0;
    endcase
  end
endmodule

// File: rtl/pc_redirect_unit_chk.sv
module pc_redirect_unit_chk #(
  parameter int SPW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [2:0]     op_kind,
  input logic [15:0]    pc_cur,
  input logic [SPW-1:0] sp_cur,
  input logic           take,
  input logic           busy,
  input logic           done,
  input logic [15:0]    pc_new,
  input logic [SPW-1:0] sp_new,
  input logic           stk_we,
  input logic           stk_re,
  input logic [SPW-1:0] stk_addr
);
  assert_no_rw_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && stk_re));

  assert_push_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_we) |=> stk_we && (stk_addr == $past(stk_addr) + SPW'(1)));

  assert_push_ends_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stk_we) |-> done);

  assert_pop_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_re) |=> stk_re && (stk_addr == $past(stk_addr) - SPW'(1)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !stk_we && !stk_re));

  assert_not_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_kind == 3'd0 && !take) |=>
      done && (pc_new == $past(pc_cur) + 16'd2) && (sp_new == $past(sp_cur)));
endmodule

bind pc_redirect_unit pc_redirect_unit_chk #(.SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind), .pc_cur(pc_cur),
  .sp_cur(sp_cur), .take(take), .busy(busy), .done(done), .pc_new(pc_new),
  .sp_new(sp_new), .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr)
);

// File: tb/pc_redirect_unit_test.sv
module pc_redirect_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W = 11;
  localparam int SPW = 8;

  logic clk = 0, rst_n = 0, start = 0, take = 0;
  logic [2:0] op_kind = 0;
  logic [15:0] pc_cur = 0, imm = 0, dptr = 0;
  logic [7:0] acc = 0, stk_rdata;
  logic [SPW-1:0] sp_cur = 0;
  logic busy, done, stk_we, stk_re;
  logic [15:0] pc_new;
  logic [SPW-1:0] sp_new, stk_addr;
  logic [7:0] stk_wdata;

  logic [7:0] stk [0:255];
  logic [7:0] rd_q;
  logic bwe = 0;
  logic [7:0] baddr = 0, bdata = 0;
  int nvec = 0, nbad = 0, nwr = 0, nrd = 0, ndone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_redirect_unit #(.PAGE_W(PAGE_W), .SPW(SPW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind), .pc_cur(pc_cur),
    .imm(imm), .acc(acc), .dptr(dptr), .sp_cur(sp_cur), .take(take),
    .stk_rdata(stk_rdata), .busy(busy), .done(done), .pc_new(pc_new),
    .sp_new(sp_new), .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata));

  always @(posedge clk) begin
    if (stk_we) stk[stk_addr] <= stk_wdata;
    else if (bwe) stk[baddr] <= bdata;
    if (stk_re) rd_q <= stk[stk_addr];
    if (stk_we) nwr <= nwr + 1;
    if (stk_re) nrd <= nrd + 1;
    if (done) ndone <= ndone + 1;
  end
  assign stk_rdata = rd_q;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bwe = 1; baddr = a; bdata = d;
    @(negedge clk); bwe = 0;
  endtask

  function automatic logic [15:0] exp_target(input logic [2:0] k, input logic [15:0] pc,
      input logic [15:0] im, input logic [7:0] a, input logic [15:0] dp, input logic t);
    logic [15:0] s;
    case (k)
      3'd0: begin s = pc + 16'd2; return t ? s + {{8{im[7]}}, im[7:0]} : s; end
      3'd1, 3'd4: begin s = pc + 16'd2; return {s[15:PAGE_W], im[PAGE_W-1:0]}; end
      3'd2, 3'd5: return im;
      3'd3: return dp + {8'd0, a};
      default: return 16'd0;
    endcase
  endfunction

  task automatic run(input logic [2:0] k, input logic [15:0] pc, input logic [15:0] im,
      input logic [7:0] a, input logic [15:0] dp, input logic [7:0] sp, input logic t,
      input bit stray);
    logic [15:0] ep, ret;
    logic [7:0] es;
    int lat, n, w0, r0, d0;
    bit is_call, is_ret;
    is_call = (k == 3'd4 || k == 3'd5);
    is_ret  = (k == 3'd6 || k == 3'd7);
    ret = pc + ((k == 3'd5) ? 16'd3 : 16'd2);
    if (is_ret) begin
      ep = {stk[sp], stk[sp - 8'd1]}; es = sp - 8'd2; lat = 4;
    end else begin
      ep = exp_target(k, pc, im, a, dp, t);
      es = is_call ? sp + 8'd2 : sp;
      lat = is_call ? 3 : 1;
    end
    @(negedge clk);
    w0 = nwr; r0 = nrd; d0 = ndone;
    op_kind = k; pc_cur = pc; imm = im; acc = a; dptr = dp; sp_cur = sp; take = t;
    start = 1;
    @(negedge clk);
    start = 0;
    n = 1;
    while (!done && n < 20) begin
      if (stray && n == 1) begin
        start = 1; op_kind = 3'd2; imm = ~im; pc_cur = ~pc; sp_cur = ~sp;
      end else start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    chk(n == lat, "R8 latency", n, lat);
    chk(pc_new == ep, $sformatf("R%0s pc kind=%0d", k == 0 ? (t ? "1" : "2") : "3457", k), pc_new, ep);
    case (k)
      3'd0: if (t) chk(pc_new == ep, "R1 taken", pc_new, ep); else chk(pc_new == ep, "R2 not taken", pc_new, ep);
      3'd1, 3'd4: chk(pc_new == ep, "R3 page target", pc_new, ep);
      3'd2, 3'd5: chk(pc_new == ep, "R4 long target", pc_new, ep);
      3'd3: chk(pc_new == ep, "R5 indexed target", pc_new, ep);
      default: chk(pc_new == ep, "R7 return target", pc_new, ep);
    endcase
    chk(sp_new == es, is_ret ? "R7 sp" : "R6 sp", sp_new, es);
    if (is_call) begin
      chk(stk[sp + 8'd1] == ret[7:0], "R6 low byte", stk[sp + 8'd1], ret[7:0]);
      chk(stk[sp + 8'd2] == ret[15:8], "R6 high byte", stk[sp + 8'd2], ret[15:8]);
    end
    @(negedge clk);
    chk(!done && !busy, "R8 single pulse", {done, busy}, 0);
    chk(nwr - w0 == (is_call ? 2 : 0), "R10 write count", nwr - w0, is_call ? 2 : 0);
    chk(nrd - r0 == (is_ret ? 2 : 0), "R10 read count", nrd - r0, is_ret ? 2 : 0);
    if (stray) begin
      @(negedge clk);
      chk(ndone - d0 == 1, "R9 stray start ignored", ndone - d0, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nvec++; nbad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !stk_we && !stk_re, "R11 reset state", {busy, done, stk_we, stk_re}, 0);
    rst_n = 1;
    for (int i = 0; i < 256; i++) poke(8'(i), 8'($urandom));

    run(3'd4, 16'h0230, 16'h0567, 0, 0, 8'h07, 0, 0);
    chk(stk[8'h08] == 8'h32 && stk[8'h09] == 8'h02, "R6 page call example", {stk[8'h09], stk[8'h08]}, 16'h0232);
    run(3'd5, 16'h0230, 16'h2034, 0, 0, 8'h07, 0, 0);
    chk(stk[8'h08] == 8'h33, "R6 long call return low", stk[8'h08], 8'h33);
    poke(8'h0A, 8'h30); poke(8'h0B, 8'h02);
    run(3'd6, 16'h1111, 0, 0, 0, 8'h0B, 0, 0);
    chk(pc_new == 16'h0230, "R7 return example", pc_new, 16'h0230);
    run(3'd0, 16'h0010, 16'h0080, 0, 0, 8'h20, 1, 0);
    chk(pc_new == 16'hFF92, "R1 backward wrap", pc_new, 16'hFF92);
    run(3'd0, 16'h1234, 16'h007F, 0, 0, 8'h20, 0, 0);
    run(3'd1, 16'h07FE, 16'h0123, 0, 0, 8'h20, 0, 0);
    chk(pc_new == 16'h0923, "R3 page from advanced pc", pc_new, 16'h0923);
    run(3'd3, 16'h0000, 0, 8'h20, 16'hFFF0, 8'h20, 0, 0);
    chk(pc_new == 16'h0010, "R5 sum wrap", pc_new, 16'h0010);
    run(3'd5, 16'hABCD, 16'h4000, 0, 0, 8'hFF, 0, 0);
    chk(sp_new == 8'h01, "R6 sp wrap", sp_new, 8'h01);
    run(3'd7, 16'h0000, 0, 0, 0, 8'h00, 0, 0);
    run(3'd4, 16'h3000, 16'h0001, 0, 0, 8'h40, 0, 1);
    run(3'd6, 16'h3000, 0, 0, 0, 8'h41, 0, 1);

    for (int i = 0; i < 400; i++)
      run(3'($urandom), 16'($urandom), 16'($urandom), 8'($urandom), 16'($urandom),
          8'($urandom), 1'($urandom), ($urandom % 8) == 0 && 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule